// File: doc/BRIEF.md
# Widening Half-Precision Multiply-Accumulate Operand Steering

This block prepares the operands for a vector fused multiply-accumulate that widens half-precision sources into single-precision lanes. It takes two 128-bit source vectors holding half-precision elements and one 128-bit accumulator vector holding single-precision lanes. It picks the active half-precision elements from the low or high part of each source, converts them bit-exactly to single precision and presents one operand triple per lane: accumulator, multiplicand and multiplier. A downstream fused multiply-add unit consumes the triple.

An operation covers either 8 bytes (two lanes) or 16 bytes (four lanes). An indexed form broadcasts one chosen element of the multiplier source to every lane. A subtract form flips the sign of the widened multiplicand. The conversion keeps signalling NaNs signalling. It can flush half-precision subnormals to zero under a control input. All sources are captured in one cycle, at the request handshake. The result therefore stays correct even when the destination register is also a source. Lanes beyond the operation size leave the block as zeros, so the destination tail is cleared.

Top module: `wmac_steer_top`

## Requirements
- R1: `req_size` code 2'b01 selects an 8-byte operation (lanes 0 and 1, `out_lane_en` = 4'b0011) and 2'b10 selects a 16-byte operation (all four lanes, `out_lane_en` = 4'b1111). Codes 2'b00 and 2'b11 are illegal. An accepted illegal request raises `err_flag` for one cycle, in the cycle after acceptance, and produces no output beat.
- R2: For a 16-byte operation, `req_upper`=1 takes source halfwords from bits 127:64 of `src_n`/`src_m` and `req_upper`=0 takes them from bits 63:0. For an 8-byte operation, `req_upper`=1 takes them from bits 63:32 and `req_upper`=0 takes them from bits 31:0.
- R3: Lane i uses halfword i of the selected chunk (chunk bits 16i+15:16i). It pairs that halfword with accumulator bits 32i+31:32i of `src_acc` and places its results at bits 32i+31:32i of each output vector.
- R4: When `req_indexed`=1, the halfword at `src_m` bits 16k+15:16k, with k = `req_index`, is the multiplier in every active lane. The multiplicand still follows R2.
- R5: When `req_sub`=1, only bit 31 of each widened multiplicand is inverted. The accumulator and multiplier values are unchanged.
- R6: Widening is exact. A normal value has its exponent rebiased by +112 and its fraction moved to bits 22:13. A zero keeps its sign. Infinity and NaN get exponent 8'hFF with the fraction copied unchanged, so a signalling NaN stays signalling.
- R7: When `flush_half`=0, a half-precision subnormal becomes the equal normal single-precision value. When `flush_half`=1, it becomes a zero of the same sign. The accumulator is never altered by this control.
- R8: In an 8-byte operation, lanes 2 and 3 of `out_acc`, `out_mul_n` and `out_mul_m` are zero.
- R9: Operands are captured at the cycle where `req_valid` and `req_ready` are both high. Later changes to the source inputs do not affect the presented beat.
- R10: `req_ready` is high when no beat is held or the held beat is taken in the same cycle. `out_valid` rises in the cycle after a legal request is accepted. A beat held with `out_ready` low keeps its value until it is taken.
- R11: After reset `out_valid` and `err_flag` are low. `req_ready` rises once the internal reset release has passed through two synchronizing flops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_size | input | 2 | Operation size code (R1) |
| req_upper | input | 1 | Select upper source part (R2) |
| req_indexed | input | 1 | Broadcast one multiplier element (R4) |
| req_sub | input | 1 | Subtract form (R5) |
| req_index | input | 3 | Multiplier halfword index for indexed form |
| flush_half | input | 1 | Flush half-precision subnormals to zero |
| src_n | input | 128 | Multiplicand source vector |
| src_m | input | 128 | Multiplier source vector |
| src_acc | input | 128 | Accumulator vector |
| out_valid | output | 1 | Operand beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_lane_en | output | 4 | Active lanes of the beat |
| out_acc | output | 128 | Accumulator lanes, tail zeroed |
| out_mul_n | output | 128 | Widened (possibly negated) multiplicand lanes |
| out_mul_m | output | 128 | Widened multiplier lanes |
| err_flag | output | 1 | One-cycle pulse for a rejected illegal size |

## Verification
The assertions assume that the downstream side drives `out_ready` from registered state and that every accepted request carries defined control fields. They also assume that a rejected request never competes with an output transfer, which the single holding stage makes true by design. The stimulus changes inputs only away from the rising edge. It throttles `out_ready` at random, holds it low on purpose to test stalls and capture, and uses every size code, so the illegal codes exercise the rejection path. Source values mix random data with directed subnormals, signed zeros, infinities and both NaN kinds.

// File: rtl/wmac_pkg.sv
package wmac_pkg;
  localparam int VEC_W        = 128;
  localparam int HALF_W       = 16;
  localparam int SGL_W        = 32;
  localparam int LANES        = VEC_W / SGL_W;
  localparam int HALVES       = VEC_W / HALF_W;
  localparam int IDX_W        = $clog2(HALVES);
  localparam int CHUNK_W      = LANES * HALF_W;
  localparam int NARROW_W     = CHUNK_W / 2;
  localparam int HALF_EXP_W   = 5;
  localparam int HALF_FRAC_W  = 10;
  localparam int SGL_EXP_W    = 8;
  localparam int SGL_FRAC_W   = 23;
  localparam int HALF_BIAS    = 15;
  localparam int SGL_BIAS     = 127;
  localparam int BIAS_DIFF    = SGL_BIAS - HALF_BIAS;
  localparam int SUB_EXP_BASE = BIAS_DIFF - HALF_FRAC_W + 1;
  localparam int LEAD_W       = $clog2(HALF_FRAC_W + 1);

  typedef enum logic [1:0] {
    SZ_BAD_LO = 2'b00,
    SZ_8B     = 2'b01,
    SZ_16B    = 2'b10,
    SZ_BAD_HI = 2'b11
  } size_code_e;
endpackage

// File: rtl/wmac_widen.sv
module wmac_widen
  import wmac_pkg::*;
(
  input  logic [HALF_W-1:0] half_i,
  input  logic              flush_i,
  output logic [SGL_W-1:0]  single_o
);
  logic                   sgn;
  logic [HALF_EXP_W-1:0]  hexp;
  logic [HALF_FRAC_W-1:0] hfrac;
  logic [LEAD_W-1:0]      lead;
  logic [LEAD_W-1:0]      shamt;
  logic [HALF_FRAC_W-1:0] nfrac;
  logic [SGL_EXP_W-1:0]   sexp;
  logic [HALF_FRAC_W-1:0] sfrac;

  assign sgn   = half_i[HALF_W-1];
  assign hexp  = half_i[HALF_W-2 -: HALF_EXP_W];
  assign hfrac = half_i[HALF_FRAC_W-1:0];

  // position of the leading one of a subnormal fraction
  always_comb begin
    lead = '0;
    for (int p = 0; p < HALF_FRAC_W; p++) begin
      if (hfrac[p]) lead = LEAD_W'(p);
    end
  end

  assign shamt = LEAD_W'(HALF_FRAC_W) - lead;
  assign nfrac = hfrac << shamt;

  always_comb begin
    sexp  = '0;
    sfrac = '0;
    if (hexp == '1) begin
      sexp  = '1;
      sfrac = hfrac;
    end else if (hexp == '0) begin
      if (hfrac != '0 && !flush_i) begin
        sexp  = SGL_EXP_W'(SUB_EXP_BASE) + SGL_EXP_W'(lead);
        sfrac = nfrac;
      end
    end else begin
      sexp  = SGL_EXP_W'(hexp) + SGL_EXP_W'(BIAS_DIFF);
      sfrac = hfrac;
    end
  end

  assign single_o = {sgn, sexp, sfrac, {(SGL_FRAC_W-HALF_FRAC_W){1'b0}}};
endmodule

// File: rtl/wmac_select.sv
module wmac_select
  import wmac_pkg::*;
(
  input  logic [VEC_W-1:0]   src_n_i,
  input  logic [VEC_W-1:0]   src_m_i,
  input  logic               wide_i,
  input  logic               upper_i,
  input  logic               indexed_i,
  input  logic [IDX_W-1:0]   index_i,
  output logic [CHUNK_W-1:0] n_chunk_o,
  output logic [CHUNK_W-1:0] m_chunk_o
);
  logic [CHUNK_W-1:0] m_direct;
  logic [HALF_W-1:0]  m_pick;

  function automatic logic [CHUNK_W-1:0] pick_chunk(
    input logic [VEC_W-1:0] v, input logic wide, input logic up);
    logic [CHUNK_W-1:0] r;
    if (wide) r = up ? v[VEC_W-1:CHUNK_W] : v[CHUNK_W-1:0];
    else      r = {{NARROW_W{1'b0}},
                   (up ? v[CHUNK_W-1:NARROW_W] : v[NARROW_W-1:0])};
    return r;
  endfunction

  always_comb begin
    m_pick = '0;
    for (int k = 0; k < HALVES; k++) begin
      if (index_i == IDX_W'(k)) m_pick = src_m_i[k*HALF_W +: HALF_W];
    end
  end

  assign n_chunk_o = pick_chunk(src_n_i, wide_i, upper_i);
  assign m_direct  = pick_chunk(src_m_i, wide_i, upper_i);
  assign m_chunk_o = indexed_i ? {LANES{m_pick}} : m_direct;
endmodule

// File: rtl/wmac_lane.sv
module wmac_lane
  import wmac_pkg::*;
(
  input  logic              en_i,
  input  logic              sub_i,
  input  logic              flush_i,
  input  logic [HALF_W-1:0] n_half_i,
  input  logic [HALF_W-1:0] m_half_i,
  input  logic [SGL_W-1:0]  acc_i,
  output logic [SGL_W-1:0]  acc_o,
  output logic [SGL_W-1:0]  n_o,
  output logic [SGL_W-1:0]  m_o
);
  logic [SGL_W-1:0] n_wide;
  logic [SGL_W-1:0] m_wide;
  logic [SGL_W-1:0] n_signed;

  wmac_widen u_widen_n (.half_i(n_half_i), .flush_i(flush_i), .single_o(n_wide));
  wmac_widen u_widen_m (.half_i(m_half_i), .flush_i(flush_i), .single_o(m_wide));

  assign n_signed = {n_wide[SGL_W-1] ^ sub_i, n_wide[SGL_W-2:0]};

  assign acc_o = en_i ? acc_i    : '0;
  assign n_o   = en_i ? n_signed : '0;
  assign m_o   = en_i ? m_wide   : '0;
endmodule

// File: rtl/wmac_steer_top.sv
module wmac_steer_top
  import wmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_size,
  input  logic             req_upper,
  input  logic             req_indexed,
  input  logic             req_sub,
  input  logic [2:0]       req_index,
  input  logic             flush_half,
  input  logic [127:0]     src_n,
  input  logic [127:0]     src_m,
  input  logic [127:0]     src_acc,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [3:0]       out_lane_en,
  output logic [127:0]     out_acc,
  output logic [127:0]     out_mul_n,
  output logic [127:0]     out_mul_m,
  output logic             err_flag
);
  // reset synchronizer: asynchronous assertion, synchronous release
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  size_code_e         size_code;
  logic               legal, wide, accept, load;
  logic [CHUNK_W-1:0] n_chunk, m_chunk;
  logic [LANES-1:0]   lane_en_d;
  logic [VEC_W-1:0]   acc_d, mn_d, mm_d;
  logic               valid_d, err_d;

  assign size_code = size_code_e'(req_size);
  assign legal     = (size_code == SZ_8B) || (size_code == SZ_16B);
  assign wide      = (size_code == SZ_16B);
  assign req_ready = rst_sync_n && (!out_valid || out_ready);
  assign accept    = req_valid && req_ready;
  assign load      = accept && legal;

  wmac_select u_select (
    .src_n_i   (src_n),
    .src_m_i   (src_m),
    .wide_i    (wide),
    .upper_i   (req_upper),
    .indexed_i (req_indexed),
    .index_i   (req_index),
    .n_chunk_o (n_chunk),
    .m_chunk_o (m_chunk)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en_d[i] = wide || (i < LANES/2);
    wmac_lane u_lane (
      .en_i     (lane_en_d[i]),
      .sub_i    (req_sub),
      .flush_i  (flush_half),
      .n_half_i (n_chunk[i*HALF_W +: HALF_W]),
      .m_half_i (m_chunk[i*HALF_W +: HALF_W]),
      .acc_i    (src_acc[i*SGL_W +: SGL_W]),
      .acc_o    (acc_d[i*SGL_W +: SGL_W]),
      .n_o      (mn_d[i*SGL_W +: SGL_W]),
      .m_o      (mm_d[i*SGL_W +: SGL_W])
    );
  end

  // next-state
  always_comb begin
    valid_d = out_valid;
    if (out_ready) valid_d = 1'b0;
    if (accept)    valid_d = legal;
    err_d = accept && !legal;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid <= 1'b0;
      err_flag  <= 1'b0;
    end else begin
      out_valid <= valid_d;
      err_flag  <= err_d;
    end
  end

  // data registers, loaded only on a legal acceptance
  always_ff @(posedge clk) begin
    if (load) begin
      out_lane_en <= lane_en_d;
      out_acc     <= acc_d;
      out_mul_n   <= mn_d;
      out_mul_m   <= mm_d;
    end
  end

  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_ready |=> out_valid && $stable(out_acc) && $stable(out_mul_n)
      && $stable(out_mul_m) && $stable(out_lane_en));

  assert_valid_cause_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(out_valid) |-> $past(req_valid && req_ready));

  assert_err_silent_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_flag |-> !out_valid);

  assert_mask_shape_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid |-> (out_lane_en == 4'b0011 || out_lane_en == 4'b1111));

  assert_tail_zero_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_valid && !out_lane_en[LANES-1] |->
      out_acc[VEC_W-1:VEC_W/2] == '0 && out_mul_n[VEC_W-1:VEC_W/2] == '0
      && out_mul_m[VEC_W-1:VEC_W/2] == '0);
endmodule

// File: tb/wmac_steer_top_tb_top.sv
`timescale 1ns/1ps
module wmac_steer_top_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_upper, req_indexed, req_sub, flush_half;
  logic [1:0] req_size;
  logic [2:0] req_index;
  logic [127:0] src_n, src_m, src_acc;
  logic out_valid, out_ready, err_flag;
  logic [3:0] out_lane_en;
  logic [127:0] out_acc, out_mul_n, out_mul_m;

  always #4 clk = ~clk; // 125 MHz

  wmac_steer_top dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_size(req_size), .req_upper(req_upper), .req_indexed(req_indexed),
    .req_sub(req_sub), .req_index(req_index), .flush_half(flush_half),
    .src_n(src_n), .src_m(src_m), .src_acc(src_acc),
    .out_valid(out_valid), .out_ready(out_ready), .out_lane_en(out_lane_en),
    .out_acc(out_acc), .out_mul_n(out_mul_n), .out_mul_m(out_mul_m),
    .err_flag(err_flag));

  typedef struct packed {
    logic         is_err;
    logic [3:0]   mask;
    logic [127:0] acc;
    logic [127:0] mn;
    logic [127:0] mm;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    checks = 0;
  int    errors = 0;
  bit    hold_low = 0;
  bit    random_bp = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  // independent model of the exact widening (R6, R7)
  function automatic logic [31:0] model_widen(input logic [15:0] h, input bit flush);
    logic [10:0] mant;
    int e;
    if (h[14:10] == 5'h1f) return {h[15], 8'hff, h[9:0], 13'b0};
    if (h[14:10] == 5'h00) begin
      if (h[9:0] == 0 || flush) return {h[15], 31'b0};
      mant = {1'b0, h[9:0]};
      e = 113;
      while (!mant[10]) begin mant = mant << 1; e--; end
      return {h[15], e[7:0], mant[9:0], 13'b0};
    end
    return {h[15], 8'(int'(h[14:10]) + 112), h[9:0], 13'b0};
  endfunction

  // backpressure driver, changes away from the sampling edge
  initial begin
    out_ready = 1'b1;
    forever begin
      @(posedge clk); #1;
      if (hold_low)       out_ready = 1'b0;
      else if (random_bp) out_ready = ($urandom % 4) != 0;
      else                out_ready = 1'b1;
    end
  end

  task automatic send(input logic [1:0] sz, input bit up, input bit idxd, input bit sb,
                      input logic [2:0] idx, input bit fl, input logic [127:0] n,
                      input logic [127:0] m, input logic [127:0] a, input string tag);
    exp_t e;
    int lanes, base;
    e = '0;
    if (sz != 2'b01 && sz != 2'b10) e.is_err = 1'b1;
    else begin
      lanes = (sz == 2'b10) ? 4 : 2;
      base  = (sz == 2'b10) ? (up ? 64 : 0) : (up ? 32 : 0);
      for (int i = 0; i < 4; i++) begin
        if (i < lanes) begin
          logic [15:0] nh, mh;
          nh = n[base + 16*i +: 16];
          mh = idxd ? m[16*int'(idx) +: 16] : m[base + 16*i +: 16];
          e.mask[i] = 1'b1;
          e.acc[32*i +: 32] = a[32*i +: 32];
          e.mn[32*i +: 32]  = model_widen(nh, fl) ^ (sb ? 32'h8000_0000 : 32'h0);
          e.mm[32*i +: 32]  = model_widen(mh, fl);
        end
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    req_valid = 1'b1; req_size = sz; req_upper = up; req_indexed = idxd;
    req_sub = sb; req_index = idx; flush_half = fl;
    src_n = n; src_m = m; src_acc = a;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    src_n = {4{$urandom}}; src_m = {4{$urandom}}; src_acc = {4{$urandom}};
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (err_flag || (out_valid && out_ready))) begin
        exp_t e;
        string t;
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected beat", {127'b0, err_flag}, 128'b0);
        end else begin
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(err_flag == e.is_err, t, "err kind", {127'b0, err_flag}, {127'b0, e.is_err});
          if (!e.is_err && !err_flag) begin
            check(out_lane_en == e.mask, t, "lane_en", {124'b0, out_lane_en}, {124'b0, e.mask});
            check(out_acc == e.acc, t, "acc", out_acc, e.acc);
            check(out_mul_n == e.mn, t, "mul_n", out_mul_n, e.mn);
            check(out_mul_m == e.mm, t, "mul_m", out_mul_m, e.mm);
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [15:0] special(input int k);
    case (k % 8)
      0: return 16'h0001;
      1: return 16'h83ff;
      2: return 16'h7c01;
      3: return 16'hfe00;
      4: return 16'h7c00;
      5: return 16'h8000;
      6: return 16'h0200;
      default: return 16'h3c00;
    endcase
  endfunction

  initial begin
    logic [127:0] sp;
    req_valid = 0; req_size = 0; req_upper = 0; req_indexed = 0; req_sub = 0;
    req_index = 0; flush_half = 0; src_n = 0; src_m = 0; src_acc = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11", "out_valid after reset", {127'b0, out_valid}, 128'b0);
    check(err_flag == 1'b0, "R11", "err_flag after reset", {127'b0, err_flag}, 128'b0);
    check(req_ready == 1'b1, "R11", "req_ready after reset", {127'b0, req_ready}, 128'b1);

    // R2 / R3 chunk selection, both sizes, both halves
    send(2'b10, 0, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R2");
    send(2'b10, 1, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R2");
    send(2'b01, 0, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R8");
    send(2'b01, 1, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R8");
    send(2'b10, 0, 0, 0, 0, 0, 128'h4400_4200_4000_3c00_c400_c200_c000_bc00,
         128'h3800_3400_3000_2c00_b800_b400_b000_ac00, rnd128(), "R3");
    // R4 indexed broadcast, every index
    for (int k = 0; k < 8; k++)
      send((k % 2) ? 2'b01 : 2'b10, k[1], 1, 0, 3'(k), 0, rnd128(), rnd128(), rnd128(), "R4");
    // R5 subtract form
    send(2'b10, 0, 0, 1, 0, 0, rnd128(), rnd128(), rnd128(), "R5");
    send(2'b01, 1, 1, 1, 3'd5, 0, rnd128(), rnd128(), rnd128(), "R5");
    // R6 / R7 special values, flush off and on
    for (int k = 0; k < 8; k++) sp[16*k +: 16] = special(k);
    send(2'b10, 0, 0, 0, 0, 0, sp, {sp[63:0], sp[127:64]}, rnd128(), "R6");
    send(2'b10, 1, 0, 0, 0, 0, sp, {sp[63:0], sp[127:64]}, rnd128(), "R6");
    send(2'b10, 0, 0, 0, 0, 1, sp, {sp[63:0], sp[127:64]}, rnd128(), "R7");
    send(2'b10, 1, 0, 1, 0, 1, sp, sp, 128'h0000_0001_8000_0001_0070_0000_0000_0001, "R7");
    // R1 illegal codes
    send(2'b00, 0, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R1");
    send(2'b11, 1, 1, 1, 3'd7, 0, rnd128(), rnd128(), rnd128(), "R1");
    send(2'b01, 0, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R1");
    repeat (3) @(negedge clk);

    // R9 / R10 capture and stall
    hold_low = 1;
    @(negedge clk);
    send(2'b10, 1, 0, 0, 0, 0, rnd128(), rnd128(), rnd128(), "R9");
    check(out_valid == 1'b1, "R10", "valid after accept", {127'b0, out_valid}, 128'b1);
    check(req_ready == 1'b0, "R10", "ready low while held", {127'b0, req_ready}, 128'b0);
    src_n = '1; src_m = '1; src_acc = '1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b1, "R10", "valid held in stall", {127'b0, out_valid}, 128'b1);
    hold_low = 0;
    repeat (3) @(negedge clk);

    // random mix with backpressure
    random_bp = 1;
    for (int t = 0; t < 200; t++) begin
      logic [127:0] rn, rm;
      rn = rnd128(); rm = rnd128();
      if (t % 3 == 0) for (int k = 0; k < 8; k++) rn[16*k +: 16] = special(t + k);
      send(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom),
           1'($urandom), rn, rm, rnd128(), "R3");
    end
    random_bp = 0;
    repeat (6) @(negedge clk);
    check(exp_q.size() == 0, "R10", "scoreboard drained", 128'(exp_q.size()), 128'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule